// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits behind the host write port of a byte-wide flash device. Each write strobe carries a 20-bit address and a data byte. The decoder follows the multi-write unlock protocol: a two-write unlock on fixed low-order addresses, then a command byte. Erase and lock commands need a setup byte and a second unlock before the final byte. When a sequence completes, the decoder emits a one-cycle operation request with an operation code, and for erase or lock it also gives the block index. It also holds the read-mode select that steers host reads to the array, the status register, the page buffer or the identifier bytes.

Acceptance depends on three flags from the operation engine: busy, suspended and error. While an operation runs, only a suspend is taken. While an erase is suspended, only read array, read status and resume are taken. While the error flag is set, only clear status, read status and read array are taken. A malformed sequence drops the decoder back to idle in array read mode. A refused command drops it back to idle and leaves the read mode as it was.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After rst_ni is released, rd_mode_o is 0 (array), op_valid_o is 0, blk_addr_o is 0 and the sequence is idle. Mode codes are 0 array, 1 status, 2 page buffer, 3 identifier.
- R2: Unlock and command writes compare only address bits [14:0] against 5555h (first unlock, command and setup writes) and 2AAAh (second unlock). Address bits [19:15] have no effect.
- R3: The sequence AAh@5555h, 55h@2AAAh, then a command byte @5555h gives: 90h → op 11 and mode 3; A0h → op 1; 75h → op 9 and mode 2; E0h → op 8; 70h → mode 1 with no request; 50h → op 10; C0h → op 6 and mode 1.
- R4: The sequence AA/55/80h, AA/55, then a sixth byte gives: 10h@5555h → op 2 (chip erase); 30h at any address → op 3 (block erase); 20h at any address → op 7 (lock). For op 3 and op 7, blk_addr_o takes address bits [19:13] of the sixth write and holds them until the next such request.
- R5: A single F0h write when idle sets mode 0. It has no effect while busy_i=1 and suspended_i=0.
- R6: A single B0h write when idle gives op 4 only if busy_i=1, suspended_i=0 and err_i=0. A single 30h write when idle gives op 5 only if suspended_i=1 and err_i=0. Otherwise both have no effect.
- R7: A write with a wrong address or data byte at any sequence step returns the decoder to idle with mode 0 and no request.
- R8: While busy_i=1 and suspended_i=0, every write other than an idle B0h leaves the sequence state, the mode and the outputs unchanged.
- R9: While suspended_i=1, only read array, read status and resume are honoured. Page-buffer read, sleep and every other command are refused: the decoder returns to idle, makes no request and keeps its mode.
- R10: While err_i=1, only clear status, read status and read array are honoured. Other commands are refused as in R9.
- R11: When sync_rst_i is high at a clock edge, the decoder returns to idle with mode 0 and blk_addr_o 0, and makes no request, whatever wr_i carries.
- R12: op_valid_o is high for exactly the one cycle after the write that completes a request. op_o encodes 1 program, 2 chip erase, 3 block erase, 4 suspend, 5 resume, 6 sleep, 7 lock, 8 write buffer, 9 read buffer, 10 clear status, 11 identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_rst_i | input | 1 | Synchronous return to idle array mode |
| wr_i | input | 1 | Host write strobe, one cycle per write |
| addr_i | input | 20 | Write address |
| data_i | input | 8 | Write data byte |
| busy_i | input | 1 | Program or erase running |
| suspended_i | input | 1 | Erase suspended |
| err_i | input | 1 | An error status bit is set |
| op_valid_o | output | 1 | One-cycle operation request |
| op_o | output | 4 | Operation code of the request |
| blk_addr_o | output | 7 | Block index for erase or lock |
| rd_mode_o | output | 2 | Read-mode select |

## Verification
The hardest cases to reach are refusals deep inside a six-write sequence, and writes that arrive while the flags change between the steps of a sequence. A command that is refused must leave the read mode untouched, and a write ignored while busy must not advance the sequence. The stimulus first sets a non-array read mode, then raises the suspended or error flag and sends complete sequences whose final byte must be refused. Random runs change the flag set between sequences and corrupt one byte at random, so partly completed sequences meet busy periods and later continue.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_PROG = 4'd1, OP_CHIP = 4'd2, OP_BLK = 4'd3,
    OP_SUSP = 4'd4, OP_RES = 4'd5, OP_SLEEP = 4'd6, OP_LOCK = 4'd7,
    OP_WRBUF = 4'd8, OP_RDBUF = 4'd9, OP_CLR = 4'd10, OP_SID = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_BUFFER = 2'd2, RM_ID = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_SETUP, SQ_UNL3, SQ_UNL4
  } seq_e;

  typedef enum logic [3:0] {
    B_OTHER, B_KEY1, B_KEY2, B_SID, B_PROG, B_RDBUF, B_WRBUF, B_RDSTAT,
    B_CLR, B_SLEEP, B_SETUP, B_CHIP, B_ERS_RES, B_LOCK, B_RESET, B_SUSP
  } byte_e;
endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int CMP_W = 15,
  parameter logic [CMP_W-1:0] UNL_A = 'h5555,
  parameter logic [CMP_W-1:0] UNL_B = 'h2AAA
) (
  input  logic [CMP_W-1:0] addr_lo_i,
  input  logic [7:0]       data_i,
  output logic             at_a_o,
  output logic             at_b_o,
  output byte_e            code_o
);
  assign at_a_o = (addr_lo_i == UNL_A);
  assign at_b_o = (addr_lo_i == UNL_B);

  always_comb begin
    unique case (data_i)
      8'hAA:   code_o = B_KEY1;
      8'h55:   code_o = B_KEY2;
      8'h90:   code_o = B_SID;
      8'hA0:   code_o = B_PROG;
      8'h75:   code_o = B_RDBUF;
      8'hE0:   code_o = B_WRBUF;
      8'h70:   code_o = B_RDSTAT;
      8'h50:   code_o = B_CLR;
      8'hC0:   code_o = B_SLEEP;
      8'h80:   code_o = B_SETUP;
      8'h10:   code_o = B_CHIP;
      8'h30:   code_o = B_ERS_RES;
      8'h20:   code_o = B_LOCK;
      8'hF0:   code_o = B_RESET;
      8'hB0:   code_o = B_SUSP;
      default: code_o = B_OTHER;
    endcase
  end
endmodule

// File: rtl/fcd_policy.sv
module fcd_policy (
  input  logic busy_i,
  input  logic suspended_i,
  input  logic err_i,
  output logic run_o,      // engine active, writes frozen
  output logic full_ok_o,  // any command allowed
  output logic clr_ok_o,   // clear status allowed
  output logic susp_ok_o,
  output logic res_ok_o
);
  assign run_o     = busy_i & ~suspended_i;
  assign full_ok_o = ~suspended_i & ~err_i;
  assign clr_ok_o  = ~suspended_i;
  assign susp_ok_o = run_o & ~err_i;
  assign res_ok_o  = suspended_i & ~err_i;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int CMP_W   = 15,
  parameter int BLK_LSB = 13,
  parameter logic [CMP_W-1:0] UNL_A = 'h5555,
  parameter logic [CMP_W-1:0] UNL_B = 'h2AAA,
  localparam int BLK_W = ADDR_W - BLK_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_rst_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  input  logic              suspended_i,
  input  logic              err_i,
  output logic              op_valid_o,
  output logic [3:0]        op_o,
  output logic [BLK_W-1:0]  blk_addr_o,
  output logic [1:0]        rd_mode_o
);
  logic  at_a, at_b;
  byte_e code;
  logic  run, full_ok, clr_ok, susp_ok, res_ok;

  fcd_classify #(.CMP_W(CMP_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) i_classify (
    .addr_lo_i(addr_i[CMP_W-1:0]), .data_i(data_i),
    .at_a_o(at_a), .at_b_o(at_b), .code_o(code)
  );

  fcd_policy i_policy (
    .busy_i(busy_i), .suspended_i(suspended_i), .err_i(err_i),
    .run_o(run), .full_ok_o(full_ok), .clr_ok_o(clr_ok),
    .susp_ok_o(susp_ok), .res_ok_o(res_ok)
  );

  seq_e             seq_q, seq_n;
  rmode_e           mode_q, mode_n;
  op_e              op_q, op_n;
  logic             vld_q, vld_n;
  logic [BLK_W-1:0] blk_q, blk_n;

  always_comb begin
    seq_n  = seq_q;
    mode_n = mode_q;
    op_n   = OP_NONE;
    vld_n  = 1'b0;
    blk_n  = blk_q;
    if (wr_i) begin
      if (run) begin
        if (seq_q == SQ_IDLE && code == B_SUSP && susp_ok) begin
          vld_n = 1'b1;
          op_n  = OP_SUSP;
        end
      end else begin
        unique case (seq_q)
          SQ_IDLE: begin
            if (code == B_KEY1 && at_a)  seq_n = SQ_UNL1;
            else if (code == B_RESET)    mode_n = RM_ARRAY;
            else if (code == B_ERS_RES) begin
              if (res_ok) begin
                vld_n = 1'b1;
                op_n  = OP_RES;
              end
            end else if (code != B_SUSP) mode_n = RM_ARRAY;
          end
          SQ_UNL1, SQ_SETUP: begin
            if (code == (seq_q == SQ_UNL1 ? B_KEY2 : B_KEY1) &&
                (seq_q == SQ_UNL1 ? at_b : at_a))
              seq_n = (seq_q == SQ_UNL1) ? SQ_UNL2 : SQ_UNL3;
            else begin
              seq_n  = SQ_IDLE;
              mode_n = RM_ARRAY;
            end
          end
          SQ_UNL3: begin
            if (code == B_KEY2 && at_b) seq_n = SQ_UNL4;
            else begin
              seq_n  = SQ_IDLE;
              mode_n = RM_ARRAY;
            end
          end
          SQ_UNL2: begin
            seq_n = SQ_IDLE;
            if (!at_a) mode_n = RM_ARRAY;
            else begin
              unique case (code)
                B_SID:    if (full_ok) begin vld_n = 1'b1; op_n = OP_SID;   mode_n = RM_ID;     end
                B_PROG:   if (full_ok) begin vld_n = 1'b1; op_n = OP_PROG;                      end
                B_RDBUF:  if (full_ok) begin vld_n = 1'b1; op_n = OP_RDBUF; mode_n = RM_BUFFER; end
                B_WRBUF:  if (full_ok) begin vld_n = 1'b1; op_n = OP_WRBUF;                     end
                B_SLEEP:  if (full_ok) begin vld_n = 1'b1; op_n = OP_SLEEP; mode_n = RM_STATUS; end
                B_CLR:    if (clr_ok)  begin vld_n = 1'b1; op_n = OP_CLR;                       end
                B_SETUP:  if (full_ok) seq_n = SQ_SETUP;
                B_RDSTAT: mode_n = RM_STATUS;
                default:  mode_n = RM_ARRAY;
              endcase
            end
          end
          SQ_UNL4: begin
            seq_n = SQ_IDLE;
            if (code == B_CHIP && at_a) begin
              if (full_ok) begin vld_n = 1'b1; op_n = OP_CHIP; end
            end else if (code == B_ERS_RES || code == B_LOCK) begin
              if (full_ok) begin
                vld_n = 1'b1;
                op_n  = (code == B_LOCK) ? OP_LOCK : OP_BLK;
                blk_n = addr_i[ADDR_W-1:BLK_LSB];
              end
            end else mode_n = RM_ARRAY;
          end
          default: begin
            seq_n  = SQ_IDLE;
            mode_n = RM_ARRAY;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= SQ_IDLE;
      mode_q <= RM_ARRAY;
      op_q   <= OP_NONE;
      vld_q  <= 1'b0;
      blk_q  <= '0;
    end else if (sync_rst_i) begin
      seq_q  <= SQ_IDLE;
      mode_q <= RM_ARRAY;
      op_q   <= OP_NONE;
      vld_q  <= 1'b0;
      blk_q  <= '0;
    end else begin
      seq_q  <= seq_n;
      mode_q <= mode_n;
      op_q   <= op_n;
      vld_q  <= vld_n;
      blk_q  <= blk_n;
    end
  end

  assign op_valid_o = vld_q;
  assign op_o       = op_q;
  assign blk_addr_o = blk_q;
  assign rd_mode_o  = mode_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int BLK_LSB = 13,
  localparam int BLK_W = ADDR_W - BLK_LSB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_rst_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              busy_i,
  input logic              suspended_i,
  input logic              err_i,
  input logic              op_valid_o,
  input logic [3:0]        op_o,
  input logic [BLK_W-1:0]  blk_addr_o,
  input logic [1:0]        rd_mode_o
);
  AST_REQ_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_i)); // R12

  AST_BUSY_ONLY_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && $past(busy_i && !suspended_i) |-> op_o == OP_SUSP); // R8

  AST_BUSY_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i && !suspended_i && !sync_rst_i) |-> $stable(rd_mode_o)); // R8

  AST_SUSP_ONLY_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && $past(suspended_i) |-> op_o == OP_RES); // R9

  AST_SUSP_NO_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(suspended_i) && rd_mode_o == RM_BUFFER |-> $stable(rd_mode_o)); // R9

  AST_ERR_ONLY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && $past(err_i) |-> op_o == OP_CLR); // R10

  AST_BLK_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o && (op_o == OP_BLK || op_o == OP_LOCK)
      |-> blk_addr_o == $past(addr_i[ADDR_W-1:BLK_LSB])); // R4

  AST_SYNC_RST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sync_rst_i) |-> !op_valid_o && rd_mode_o == RM_ARRAY && blk_addr_o == '0); // R11
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) i_fcd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_rst_i(sync_rst_i), .wr_i(wr_i),
  .addr_i(addr_i), .busy_i(busy_i), .suspended_i(suspended_i), .err_i(err_i),
  .op_valid_o(op_valid_o), .op_o(op_o), .blk_addr_o(blk_addr_o), .rd_mode_o(rd_mode_o)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk_i = 1'b0, rst_ni = 1'b0, sync_rst_i = 1'b0, wr_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic [7:0]  data_i = '0;
  logic        busy_i = 1'b0, suspended_i = 1'b0, err_i = 1'b0;
  logic        op_valid_o;
  logic [3:0]  op_o;
  logic [6:0]  blk_addr_o;
  logic [1:0]  rd_mode_o;

  flash_cmd_decoder i_flash_cmd_decoder (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  int m_st = 0;
  logic       e_vld = 1'b0;
  logic [3:0] e_op = '0;
  logic [6:0] e_blk = '0;
  logic [1:0] e_mode = '0;

  task automatic chk(input string tag);
    logic [3:0] aop;
    aop = op_valid_o ? op_o : 4'd0;
    total++;
    if (op_valid_o !== e_vld || aop !== e_op || blk_addr_o !== e_blk || rd_mode_o !== e_mode) begin
      bad++;
      $display("FAIL %s: got vld=%0d op=%0d blk=%h mode=%0d exp vld=%0d op=%0d blk=%h mode=%0d",
               tag, op_valid_o, aop, blk_addr_o, rd_mode_o, e_vld, e_op, e_blk, e_mode);
    end
  endtask

  function automatic void req(input logic [3:0] op);
    e_vld = 1'b1;
    e_op  = op;
  endfunction

  // reference model of the decoder, from the requirements
  function automatic void model_wr(input logic [19:0] a, input logic [7:0] d);
    logic run, ok, is5, is2;
    run = busy_i && !suspended_i;
    ok  = !suspended_i && !err_i;
    is5 = a[14:0] == 15'h5555;
    is2 = a[14:0] == 15'h2AAA;
    e_vld = 1'b0;
    e_op  = 4'd0;
    if (run) begin
      if (m_st == 0 && d == 8'hB0 && !err_i) req(4'd4);
      return;
    end
    case (m_st)
      0: begin
        if (d == 8'hAA && is5) m_st = 1;
        else if (d == 8'hF0) e_mode = 2'd0;
        else if (d == 8'h30) begin if (suspended_i && !err_i) req(4'd5); end
        else if (d != 8'hB0) e_mode = 2'd0;
      end
      1: if (d == 8'h55 && is2) m_st = 2; else begin m_st = 0; e_mode = 2'd0; end
      3: if (d == 8'hAA && is5) m_st = 4; else begin m_st = 0; e_mode = 2'd0; end
      4: if (d == 8'h55 && is2) m_st = 5; else begin m_st = 0; e_mode = 2'd0; end
      2: begin
        m_st = 0;
        if (!is5) e_mode = 2'd0;
        else case (d)
          8'h90: if (ok) begin req(4'd11); e_mode = 2'd3; end
          8'hA0: if (ok) req(4'd1);
          8'h75: if (ok) begin req(4'd9); e_mode = 2'd2; end
          8'hE0: if (ok) req(4'd8);
          8'hC0: if (ok) begin req(4'd6); e_mode = 2'd1; end
          8'h50: if (!suspended_i) req(4'd10);
          8'h80: if (ok) m_st = 3;
          8'h70: e_mode = 2'd1;
          default: e_mode = 2'd0;
        endcase
      end
      default: begin
        m_st = 0;
        if (d == 8'h10 && is5) begin if (ok) req(4'd2); end
        else if (d == 8'h30 || d == 8'h20) begin
          if (ok) begin req(d == 8'h20 ? 4'd7 : 4'd3); e_blk = a[19:13]; end
        end else e_mode = 2'd0;
      end
    endcase
  endfunction

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input string tag);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; data_i = d;
    model_wr(a, d);
    @(negedge clk_i);
    wr_i = 1'b0;
    chk(tag);
    @(negedge clk_i);
    e_vld = 1'b0; e_op = 4'd0;
    chk({tag, " R12 idle"});
  endtask

  task automatic flags(input logic b, input logic s, input logic e);
    @(negedge clk_i);
    busy_i = b; suspended_i = s; err_i = e;
  endtask

  task automatic cmd3(input logic [4:0] hi, input logic [7:0] c, input string tag);
    wr({hi, 15'h5555}, 8'hAA, tag);
    wr({hi, 15'h2AAA}, 8'h55, tag);
    wr({hi, 15'h5555}, c, tag);
  endtask

  task automatic cmd6(input logic [19:0] a6, input logic [7:0] c, input string tag);
    cmd3(5'h0, 8'h80, tag);
    wr(20'h05555, 8'hAA, tag);
    wr(20'h02AAA, 8'h55, tag);
    wr(a6, c, tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset state");

    // R2: high address bits ignored; wrong low bits break the unlock
    cmd3(5'h1F, 8'h70, "R2 high bits");
    wr(20'h05554, 8'hAA, "R2 bad low bits");
    // R3: three-write commands
    cmd3(5'h0, 8'h90, "R3 sid");
    cmd3(5'h0, 8'hA0, "R3 prog");
    cmd3(5'h0, 8'h75, "R3 rdbuf");
    cmd3(5'h0, 8'hE0, "R3 wrbuf");
    cmd3(5'h0, 8'h50, "R3 clr");
    cmd3(5'h0, 8'hC0, "R3 sleep");
    // R4: six-write commands and block index
    cmd6(20'hE6000, 8'h30, "R4 block erase");
    cmd6(20'h3FFFF, 8'h20, "R4 lock");
    cmd6(20'hA5555, 8'h10, "R4 chip erase");
    cmd6(20'h15554, 8'h10, "R4 chip erase bad addr");
    // R5: F0 resets, ignored while running
    cmd3(5'h0, 8'h70, "R5 setup");
    wr(20'h12345, 8'hF0, "R5 reset");
    cmd3(5'h0, 8'h70, "R5 setup");
    flags(1, 0, 0);
    wr(20'h12345, 8'hF0, "R5 ignored busy");
    // R6/R8: suspend while running, other writes frozen
    wr(20'h00000, 8'hB0, "R6 suspend");
    cmd3(5'h0, 8'h90, "R8 frozen");
    wr(20'h00000, 8'h30, "R8 resume ignored while running");
    flags(0, 0, 0);
    wr(20'h00000, 8'hB0, "R6 suspend ignored idle");
    wr(20'h00000, 8'h30, "R6 resume ignored idle");
    // R8: partial sequence held across busy period
    wr(20'h05555, 8'hAA, "R8 partial");
    flags(1, 0, 0);
    wr(20'h00000, 8'h11, "R8 held");
    flags(0, 0, 0);
    wr(20'h02AAA, 8'h55, "R8 resume seq");
    wr(20'h05555, 8'h75, "R8 complete");
    // R9: suspended filter
    flags(1, 1, 0);
    cmd3(5'h0, 8'h70, "R9 rdstat ok");
    cmd3(5'h0, 8'h75, "R9 rdbuf refused");
    cmd3(5'h0, 8'hC0, "R9 sleep refused");
    cmd3(5'h0, 8'h80, "R9 setup refused");
    wr(20'h00000, 8'hB0, "R9 suspend ignored");
    wr(20'h00000, 8'h30, "R9 resume");
    wr(20'h00000, 8'hF0, "R9 read array");
    // R10: error filter
    flags(0, 0, 1);
    cmd3(5'h0, 8'h70, "R10 rdstat ok");
    cmd3(5'h0, 8'hA0, "R10 prog refused");
    cmd3(5'h0, 8'h90, "R10 sid refused");
    cmd3(5'h0, 8'h50, "R10 clr ok");
    flags(0, 0, 0);
    // R7: corruption at each step
    wr(20'h05555, 8'hAA, "R7"); wr(20'h02AAB, 8'h55, "R7 bad addr step2");
    cmd3(5'h0, 8'h70, "R7 setup");
    cmd3(5'h0, 8'h33, "R7 bad cmd");
    cmd3(5'h0, 8'h70, "R7 setup");
    cmd3(5'h0, 8'h80, "R7"); wr(20'h05555, 8'hAB, "R7 bad step4");
    // R11: synchronous reset mid-sequence, with a write at the same edge
    cmd3(5'h0, 8'h70, "R11 setup");
    wr(20'h05555, 8'hAA, "R11 partial");
    @(negedge clk_i);
    sync_rst_i = 1'b1; wr_i = 1'b1; addr_i = 20'h02AAA; data_i = 8'h55;
    @(negedge clk_i);
    sync_rst_i = 1'b0; wr_i = 1'b0;
    m_st = 0; e_mode = 2'd0; e_vld = 1'b0; e_op = 4'd0; e_blk = '0;
    chk("R11 sync reset");
    wr(20'h05555, 8'h70, "R11 after reset");

    // random sequences
    void'($urandom(32'h5eed));
    for (int n = 0; n < 700; n++) begin
      logic [19:0] a [6];
      logic [7:0]  d [6];
      int len, r;
      r = $urandom % 10;
      case (r)
        0: flags(1, 0, 0);
        1: flags(1, 1, 0);
        2: flags(0, 0, 1);
        3: flags(1, 1, 1);
        default: flags(0, 0, 0);
      endcase
      for (int i = 0; i < 6; i++) a[i] = {$urandom % 32, (i % 3 == 1) ? 15'h2AAA : 15'h5555};
      d[0] = 8'hAA; d[1] = 8'h55; d[3] = 8'hAA; d[4] = 8'h55;
      r = $urandom % 14;
      len = 3;
      case (r)
        0: d[2] = 8'h90;  1: d[2] = 8'hA0;  2: d[2] = 8'h75;  3: d[2] = 8'hE0;
        4: d[2] = 8'h70;  5: d[2] = 8'h50;  6: d[2] = 8'hC0;
        7:  begin len = 6; d[2] = 8'h80; d[5] = 8'h10; end
        8:  begin len = 6; d[2] = 8'h80; d[5] = 8'h30; a[5] = $urandom; end
        9:  begin len = 6; d[2] = 8'h80; d[5] = 8'h20; a[5] = $urandom; end
        10: begin len = 1; d[0] = 8'hF0; a[0] = $urandom; end
        11: begin len = 1; d[0] = 8'hB0; a[0] = $urandom; end
        12: begin len = 1; d[0] = 8'h30; a[0] = $urandom; end
        default: begin len = 1; d[0] = $urandom; a[0] = $urandom; end
      endcase
      if ($urandom % 8 == 0) begin
        r = $urandom % len;
        if ($urandom % 2 == 0) d[r] = $urandom; else a[r] = $urandom;
      end
      for (int i = 0; i < len; i++) wr(a[i], d[i], "R3 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule